// File: doc/BRIEF.md
# I2C Combined-Format Read Engine

This block is a host-side I2C master that runs one fixed transaction: it writes a single offset byte to a 7-bit slave address, turns the bus around with a repeated start, and reads a programmed number of bytes back from the same slave. It is meant for register-style peripherals such as serial memories, where one written byte picks the location and the following reads stream data out of it.

Software places the slave address, the offset byte and the byte count on the inputs and pulses a start strobe. The block drives open-drain SCL and SDA through pull-low enables, samples SDA through a synchronizer, and hands each received byte out with a one-cycle valid pulse. It ends with a one-cycle done pulse. A sticky error flag reports a rejected request or a slave that did not acknowledge. SCL timing comes from a quarter-bit divider that is set at run time. There is no clock stretching, no arbitration, no packet error checking and no 10-bit addressing.

Top module: `i2c_cmb_reader`

## Requirements
- R1: While rst_ni is low and after its release, scl_oe_o, sda_oe_o, busy_o, done_o, err_o and rx_valid_o are all 0.
- R2: An accepted request starts with a START (SDA falls while SCL is high). Then the first frame carries the 7 address bits MSB first followed by a 0 (write). In the ninth slot the block releases SDA to sample the slave's acknowledge, where low means ACK.
- R3: After an ACKed address frame the block sends the offset byte MSB first, then samples a second acknowledge.
- R4: After an ACKed offset byte the block issues a repeated START, not a STOP. It then sends the same 7 address bits with a 1 (read) and samples a third acknowledge. A full transaction shows exactly two START conditions.
- R5: Exactly cnt_i bytes are read, MSB first. Each one appears on rx_data_o with a one-cycle rx_valid_o pulse.
- R6: The master pulls SDA low in the acknowledge slot after every data byte except the last. After the last byte it leaves SDA high (NAK), then generates exactly one STOP (SDA rises while SCL is high).
- R7: If any of the three address/offset acknowledge slots reads high, the block generates a STOP, reads no data, and ends with done_o pulsing and err_o set. err_o is cleared when the next request is accepted.
- R8: A request with cnt_i equal to 0 pulses done_o with err_o set on the next cycle. busy_o stays low and the bus is never touched.
- R9: busy_o goes high the cycle after an accepted strobe and stays high until the STOP completes. It falls in the same cycle as the done_o pulse. Strobes that arrive while busy_o is high are ignored, and the transaction keeps the address and offset latched at acceptance.
- R10: SDA changes only while SCL is low, except in START, repeated START and STOP. In the address frame the SCL period is 4*(div_i+1) clock cycles.
- R11: Whenever busy_o is low, both scl_oe_o and sda_oe_o are 0 (lines released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W (8) | Quarter-bit length minus one, in clock cycles (at least 2) |
| start_i | input | 1 | One-cycle request strobe |
| addr_i | input | 7 | Slave address |
| offs_i | input | 8 | Offset byte written before the read |
| cnt_i | input | CNT_W (8) | Number of bytes to read |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when a request ends |
| err_o | output | 1 | Sticky error: zero count or slave NAK |
| rx_valid_o | output | 1 | One-cycle pulse with each received byte |
| rx_data_o | output | 8 | Last received byte |

## Verification
The assertions assume that div_i is at least 2 and held steady during a transaction, that start_i is a single-cycle pulse, and that the request inputs are stable on the strobe cycle. The SDA stability property only watches the block's own enables, so it relies on no other agent on the bus changing SDA while SCL is high. The bench keeps within these limits. It sets div_i between transactions only and drives every strobe for exactly one cycle from a falling clock edge. Its slave model changes SDA only on SCL falling edges.

// File: rtl/i2c_cr_pkg.sv
`timescale 1ns/1ps
package i2c_cr_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    BC_START, BC_RSTART, BC_STOP, BC_WBIT, BC_RBIT
  } bit_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_TXB, S_RXACK, S_RSTART, S_RXB, S_TXACK, S_STOP
  } seq_e;

  typedef enum logic [1:0] {
    F_ADDR_W, F_OFFS, F_ADDR_R
  } frame_e;
endpackage

// File: rtl/i2c_cr_tick.sv
`timescale 1ns/1ps
module i2c_cr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cr_sync.sv
`timescale 1ns/1ps
module i2c_cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_q <= '1;  // idle bus reads high
      end else begin
        sr_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
      end
    end
    assign q_o = sr_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_cr_phy.sv
`timescale 1ns/1ps
module i2c_cr_phy
  import i2c_cr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     cmd_valid_i,
  input  bit_cmd_e cmd_i,
  input  logic     wbit_i,
  input  logic     sda_i,
  output logic     busy_o,
  output logic     done_o,
  output logic     rbit_o,
  output logic     scl_oe_o,
  output logic     sda_oe_o
);
  logic     busy_q, done_q, rbit_q, wbit_q;
  logic     scl_oe_q, sda_oe_q;
  logic [1:0] phase_q;
  bit_cmd_e cmd_q;
  logic     scl_hi, sda_hi;

  // Line levels per quarter; each command leaves SCL low except STOP
  always_comb begin
    scl_hi = 1'b1;
    sda_hi = 1'b1;
    unique case (cmd_q)
      BC_START: begin
        scl_hi = (phase_q != 2'd3);
        sda_hi = (phase_q == 2'd0);
      end
      BC_RSTART: begin
        scl_hi = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_hi = (phase_q < 2'd2);
      end
      BC_STOP: begin
        scl_hi = (phase_q != 2'd0);
        sda_hi = (phase_q >= 2'd2);
      end
      BC_WBIT: begin
        scl_hi = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_hi = wbit_q;
      end
      default: begin
        scl_hi = (phase_q == 2'd1) || (phase_q == 2'd2);
        sda_hi = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rbit_q   <= 1'b1;
      wbit_q   <= 1'b1;
      phase_q  <= 2'd0;
      cmd_q    <= BC_START;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        scl_oe_q <= !scl_hi;
        sda_oe_q <= !sda_hi;
        if (tick_i) begin
          if (phase_q == 2'd2 && cmd_q == BC_RBIT) rbit_q <= sda_i;
          if (phase_q == 2'd3) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
          phase_q <= phase_q + 2'd1;
        end
      end else if (cmd_valid_i) begin
        busy_q  <= 1'b1;
        phase_q <= 2'd0;
        cmd_q   <= cmd_i;
        wbit_q  <= wbit_i;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rbit_o   = rbit_q;
  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_cmb_reader.sv
`timescale 1ns/1ps
module i2c_cmb_reader
  import i2c_cr_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] offs_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  seq_e              state_q;
  frame_e            frame_q;
  logic [BIT_CW-1:0] bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] offs_q;
  logic              issued_q, done_q, err_q, rxv_q;
  logic [BYTE_W-1:0] rxd_q;

  logic     tick, sda_s;
  logic     phy_busy, phy_done, phy_rbit;
  logic     cmd_valid, wbit;
  bit_cmd_e cmd;

  i2c_cr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  i2c_cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  i2c_cr_phy u_phy (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .wbit_i(wbit), .sda_i(sda_s),
    .busy_o(phy_busy), .done_o(phy_done), .rbit_o(phy_rbit),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  always_comb begin
    cmd  = BC_START;
    wbit = 1'b1;
    unique case (state_q)
      S_START:  cmd = BC_START;
      S_RSTART: cmd = BC_RSTART;
      S_STOP:   cmd = BC_STOP;
      S_TXB: begin
        cmd  = BC_WBIT;
        wbit = sh_q[BYTE_W-1];
      end
      S_TXACK: begin
        cmd  = BC_WBIT;
        wbit = (rem_q == '0);  // NAK on the final byte
      end
      S_RXACK, S_RXB: cmd = BC_RBIT;
      default: cmd = BC_START;
    endcase
  end

  assign cmd_valid = (state_q != S_IDLE) && !issued_q && !phy_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      frame_q  <= F_ADDR_W;
      bit_q    <= '0;
      sh_q     <= '0;
      rem_q    <= '0;
      addr_q   <= '0;
      offs_q   <= '0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rxv_q    <= 1'b0;
      rxd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (phy_done)       issued_q <= 1'b0;
      else if (cmd_valid) issued_q <= 1'b1;

      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (cnt_i == '0) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            err_q   <= 1'b0;
            addr_q  <= addr_i;
            offs_q  <= offs_i;
            rem_q   <= cnt_i;
            state_q <= S_START;
          end
        end
        S_START: if (phy_done) begin
          sh_q    <= {addr_q, 1'b0};
          frame_q <= F_ADDR_W;
          bit_q   <= LAST_BIT;
          state_q <= S_TXB;
        end
        S_TXB: if (phy_done) begin
          if (bit_q == '0) begin
            state_q <= S_RXACK;
          end else begin
            bit_q <= bit_q - BIT_CW'(1);
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
          end
        end
        S_RXACK: if (phy_done) begin
          if (phy_rbit) begin
            err_q   <= 1'b1;
            state_q <= S_STOP;
          end else begin
            unique case (frame_q)
              F_ADDR_W: begin
                sh_q    <= offs_q;
                frame_q <= F_OFFS;
                bit_q   <= LAST_BIT;
                state_q <= S_TXB;
              end
              F_OFFS: state_q <= S_RSTART;
              default: begin
                bit_q   <= LAST_BIT;
                state_q <= S_RXB;
              end
            endcase
          end
        end
        S_RSTART: if (phy_done) begin
          sh_q    <= {addr_q, 1'b1};
          frame_q <= F_ADDR_R;
          bit_q   <= LAST_BIT;
          state_q <= S_TXB;
        end
        S_RXB: if (phy_done) begin
          sh_q <= {sh_q[BYTE_W-2:0], phy_rbit};
          if (bit_q == '0) begin
            rxv_q   <= 1'b1;
            rxd_q   <= {sh_q[BYTE_W-2:0], phy_rbit};
            rem_q   <= rem_q - CNT_W'(1);
            state_q <= S_TXACK;
          end else begin
            bit_q <= bit_q - BIT_CW'(1);
          end
        end
        S_TXACK: if (phy_done) begin
          if (rem_q == '0) begin
            state_q <= S_STOP;
          end else begin
            bit_q   <= LAST_BIT;
            state_q <= S_RXB;
          end
        end
        S_STOP: if (phy_done) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;
endmodule

// File: rtl/i2c_cmb_reader_chk.sv
`timescale 1ns/1ps
module i2c_cmb_reader_chk
  import i2c_cr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              rx_valid_o,
  input seq_e              state_i,
  input logic [ADDR_W-1:0] addr_q_i,
  input logic [BYTE_W-1:0] offs_q_i
);
  logic in_data;
  assign in_data = (state_i == S_TXB) || (state_i == S_RXACK) ||
                   (state_i == S_RXB) || (state_i == S_TXACK);

  p_released_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  p_sda_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && !scl_oe_o && $past(!scl_oe_o)) |-> $stable(sda_oe_o));

  p_busy_ignores_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(addr_q_i) && $stable(offs_q_i)));

  p_done_ends_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_zero_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && cnt_i == '0) |=> (done_o && err_o && !busy_o));

  p_rx_inside_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> busy_o);

  p_no_rx_after_nak_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && busy_o) |-> !rx_valid_o);
endmodule

bind i2c_cmb_reader i2c_cmb_reader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cnt_i(cnt_i),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .rx_valid_o(rx_valid_o),
  .state_i(state_q), .addr_q_i(addr_q), .offs_q_i(offs_q)
);

// File: tb/i2c_cmb_reader_bench.sv
`timescale 1ns/1ps
module i2c_cmb_reader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = 8'd3;
  logic       start_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [7:0] offs_i = '0;
  logic [7:0] cnt_i = '0;
  logic       scl_oe, sda_oe, busy_o, done_o, err_o, rx_valid_o;
  logic [7:0] rx_data_o;
  logic       scl, sda;
  logic       slv_drv = 1'b0;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | slv_drv);

  always #10 clk = ~clk;

  i2c_cmb_reader u_i2c_cmb_reader (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_i), .start_i(start_i),
    .addr_i(addr_i), .offs_i(offs_i), .cnt_i(cnt_i), .sda_i(sda),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] x);
    return (x * 8'd37) ^ 8'h5A;
  endfunction

  // slave model
  logic [6:0] s_addr = 7'h3A;
  bit nak_w = 0, nak_o = 0, nak_r = 0;
  bit active = 0, in_addr = 0, mode_tx = 0, pend_tx = 0, mack = 0;
  int bcnt = 0, rd_idx = 0;
  logic [7:0] sh = '0, txb = '0, s_off = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int n_start = 0, n_stop = 0, n_frames = 0, n_mack = 0;
  logic [7:0] frame_log [8];
  logic       mack_log [16];
  time t_last_rise = 0, per_addr = 0;

  always @(scl or sda) begin
    if (scl === 1'b1 && prev_scl === 1'b1 && prev_sda === 1'b1 && sda === 1'b0) begin
      n_start++; active = 1; mode_tx = 0; pend_tx = 0; bcnt = 0; in_addr = 1;
      slv_drv <= 1'b0;
    end else if (scl === 1'b1 && prev_scl === 1'b1 && prev_sda === 1'b0 && sda === 1'b1) begin
      n_stop++; active = 0; mode_tx = 0;
      slv_drv <= 1'b0;
    end else if (scl === 1'b1 && prev_scl === 1'b0) begin
      if (active && in_addr && bcnt == 3) per_addr = $time - t_last_rise;
      t_last_rise = $time;
      if (active) begin
        if (!mode_tx) begin
          if (bcnt < 8) sh = {sh[6:0], sda};
        end else if (bcnt == 8) begin
          mack = sda;
          if (n_mack < 16) mack_log[n_mack] = sda;
          n_mack++;
        end
        bcnt = (bcnt == 8) ? 0 : bcnt + 1;
      end
    end else if (scl === 1'b0 && prev_scl === 1'b1) begin
      if (!active) slv_drv <= 1'b0;
      else if (!mode_tx) begin
        if (bcnt == 8) begin
          if (n_frames < 8) frame_log[n_frames] = sh;
          n_frames++;
          if (in_addr) begin
            bit ok;
            ok = (sh[7:1] == s_addr) && !(sh[0] ? nak_r : nak_w);
            slv_drv <= ok;
            pend_tx = ok && sh[0];
            in_addr = 0;
          end else begin
            s_off = sh; rd_idx = 0;
            slv_drv <= !nak_o;
          end
        end else if (bcnt == 0 && pend_tx) begin
          mode_tx = 1; pend_tx = 0;
          txb = exp_byte(s_off + 8'(rd_idx)); rd_idx++;
          slv_drv <= ~txb[7];
        end else slv_drv <= 1'b0;
      end else begin
        if (bcnt == 8) slv_drv <= 1'b0;
        else if (bcnt == 0) begin
          if (!mack) begin
            txb = exp_byte(s_off + 8'(rd_idx)); rd_idx++;
            slv_drv <= ~txb[7];
          end else begin
            slv_drv <= 1'b0; active = 0;
          end
        end else slv_drv <= ~txb[7-bcnt];
      end
    end
    prev_scl = scl;
    prev_sda = sda;
  end

  // received byte monitor
  logic [7:0] rx_buf [16];
  int rx_n = 0;
  always @(negedge clk) if (rx_valid_o === 1'b1) begin
    if (rx_n < 16) rx_buf[rx_n] = rx_data_o;
    rx_n++;
  end

  logic busy_after, busy_at_done, err_at_done;

  task automatic clear_logs();
    n_start = 0; n_stop = 0; n_frames = 0; n_mack = 0; rx_n = 0; per_addr = 0;
    nak_w = 0; nak_o = 0; nak_r = 0; s_addr = 7'h3A;
  endtask

  task automatic run(input logic [6:0] a, input logic [7:0] o, input logic [7:0] n,
                     input int poke_at);
    int cyc;
    @(negedge clk);
    addr_i = a; offs_i = o; cnt_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    busy_after = busy_o;
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin
        addr_i = ~a; offs_i = ~o; cnt_i = 8'd9; start_i = 1'b1;
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    if (cyc >= 40000) chk("R9 done timeout", 0, 1);
    busy_at_done = busy_o;
    err_at_done = err_o;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy/done/err/rxv", {busy_o, done_o, err_o, rx_valid_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {scl_oe, sda_oe, busy_o, done_o, err_o, rx_valid_o}, 0);
    chk("R11 lines idle", {scl, sda}, 2'b11);
  endtask

  task automatic t_single();
    clear_logs();
    run(7'h3A, 8'h10, 8'd1, 0);
    chk("R2 write address frame", frame_log[0], {7'h3A, 1'b0});
    chk("R3 offset frame", frame_log[1], 8'h10);
    chk("R4 read address frame", frame_log[2], {7'h3A, 1'b1});
    chk("R4 two starts", n_start, 2);
    chk("R5 one byte", rx_n, 1);
    chk("R5 byte value", rx_buf[0], exp_byte(8'h10));
    chk("R6 final NAK", mack_log[0], 1);
    chk("R6 one stop", n_stop, 1);
    chk("R7 no error", err_at_done, 0);
    chk("R9 busy after strobe", busy_after, 1);
    chk("R9 busy low at done", busy_at_done, 0);
    chk("R10 scl period div3", per_addr, 320);
    chk("R11 released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_multi();
    clear_logs();
    run(7'h3A, 8'hFD, 8'd5, 0);
    chk("R5 five bytes", rx_n, 5);
    for (int k = 0; k < 5; k++) chk("R5 byte", rx_buf[k], exp_byte(8'hFD + 8'(k)));
    chk("R6 acks seen", n_mack, 5);
    for (int k = 0; k < 4; k++) chk("R6 master ACK", mack_log[k], 0);
    chk("R6 last NAK", mack_log[4], 1);
    chk("R6 stop", n_stop, 1);
  endtask

  task automatic t_nak_addr();
    clear_logs();
    s_addr = 7'h11;
    run(7'h3A, 8'h20, 8'd3, 0);
    chk("R7 err on address NAK", err_at_done, 1);
    chk("R7 frames", n_frames, 1);
    chk("R7 one start", n_start, 1);
    chk("R7 stop", n_stop, 1);
    chk("R7 no data", rx_n, 0);
  endtask

  task automatic t_nak_offs();
    clear_logs();
    nak_o = 1;
    run(7'h3A, 8'h21, 8'd3, 0);
    chk("R7 err on offset NAK", err_at_done, 1);
    chk("R7 frames offs", n_frames, 2);
    chk("R7 no restart", n_start, 1);
    chk("R7 no data offs", rx_n, 0);
  endtask

  task automatic t_nak_raddr();
    clear_logs();
    nak_r = 1;
    run(7'h3A, 8'h22, 8'd2, 0);
    chk("R7 err on read address NAK", err_at_done, 1);
    chk("R7 frames raddr", n_frames, 3);
    chk("R7 stop raddr", n_stop, 1);
    chk("R7 no data raddr", rx_n, 0);
  endtask

  task automatic t_zero();
    clear_logs();
    @(negedge clk);
    addr_i = 7'h3A; offs_i = 8'h01; cnt_i = 8'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 done pulse", done_o, 1);
    chk("R8 err set", err_o, 1);
    chk("R8 busy stays low", busy_o, 0);
    repeat (100) @(negedge clk);
    chk("R8 no bus activity", n_start + n_stop, 0);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_busy_ignore();
    clear_logs();
    run(7'h3A, 8'h40, 8'd2, 60);
    chk("R9 address kept", frame_log[0], {7'h3A, 1'b0});
    chk("R9 offset kept", frame_log[1], 8'h40);
    chk("R9 count kept", rx_n, 2);
    chk("R9 data from kept offset", rx_buf[1], exp_byte(8'h41));
  endtask

  task automatic t_period();
    clear_logs();
    div_i = 8'd5;
    run(7'h3A, 8'h05, 8'd1, 0);
    chk("R10 scl period div5", per_addr, 480);
    chk("R10 start/stop counts", {n_start[7:0], n_stop[7:0]}, {8'd2, 8'd1});
    div_i = 8'd3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_nak_addr();
    t_nak_offs();
    t_nak_raddr();
    t_single();
    t_zero();
    t_busy_ignore();
    t_period();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule